// File: doc/BRIEF.md
# Addressable LED Serial Encoder

This block converts a stream of pixel colour words into the single-wire serial waveform that common addressable RGB and RGBW LED strips expect. Every data bit is a pulse with a fixed period, and the bit value sets how long the pulse stays high. Pixels arrive on a valid/ready interface that carries a last-pixel marker. Each pixel becomes three or four bytes, sent most significant bit first, in a byte order chosen by a parameter. The line is low at idle.

A frame starts with the first pixel accepted while idle. The next pixel is taken during the final bit of the current one, so the bit stream has no breaks. After the last pixel the line stays low for a latch gap so the strip can show the frame.

If no pixel is offered when one is needed, and the current pixel was not marked last, the frame is cut short. An underrun flag is raised and the same latch gap follows. Bit timings and the gap length are derived from the clock frequency parameter.

Top module: `led_serial_tx`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `in_ready` is low, `dout` is low and `busy` is low. From the next cycle on, `in_ready` is high while idle.
- R2: Every bit cell lasts 1250 ns rounded to whole clock cycles, which is 125 cycles at 100 MHz.
- R3: A one bit drives `dout` high for 900 ns (90 cycles at 100 MHz) and low for the rest of the cell.
- R4: A zero bit drives `dout` high for 350 ns (35 cycles at 100 MHz) and low for the rest of the cell.
- R5: Each byte is sent most significant bit first.
- R6: The parameter `ORDER` selects the byte order of each pixel. The default ORD_GRB (encoding 0) sends green, red, blue. ORD_RGB (1) sends red, green, blue. ORD_BGR (2) sends blue, green, red.
- R7: When `HAS_WHITE` is 1, a white byte follows the three colour bytes of every pixel, giving 32 bits per pixel instead of 24.
- R8: A pixel offered at any cycle of the final bit of the previous pixel, including the final cycle of that bit, starts on the very next cell. The bit stream has no gaps.
- R9: After the last bit of a frame, `dout` stays low for `GAP_US` microseconds (`GAP_US`×`CLK_HZ`/10^6 cycles). During that time `busy` stays high and `in_ready` stays low.
- R10: If a pixel that was not marked last ends and no next pixel has been taken, `underrun` goes high and the frame ends with the latch gap. `underrun` stays high until the next frame starts.
- R11: `busy` is high from the cycle after the first pixel of a frame is accepted until the gap is over. For N pixels of B bits at 100 MHz, that span is N·B·125 cycles plus the gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Pixel can be taken this cycle |
| in_last | input | 1 | Offered pixel closes the frame |
| in_red | input | 8 | Red intensity |
| in_green | input | 8 | Green intensity |
| in_blue | input | 8 | Blue intensity |
| in_white | input | 8 | White intensity, used only when HAS_WHITE is 1 |
| dout | output | 1 | Serial line to the strip |
| busy | output | 1 | Frame in progress, including the latch gap |
| underrun | output | 1 | Last frame was cut short for lack of a pixel |

## Verification
The handover from one pixel to the next can land in the same cycle as the last clock of the outgoing bit. In that case a pixel accepted in that cycle must be loaded directly, without passing through the holding register. The bench forces this case by counting exactly 2999 cycles after the first pixel of a frame is accepted, then offering the second pixel so that it is taken on the final cycle of bit 23. The waveform is decoded, and every cell period across the pixel boundary must be exactly 125 cycles. No underrun may appear. In a separate frame the supply of pixels is cut off, and the bench checks that the underrun flag and the latch gap both appear after one pixel.

// File: rtl/led_tx_pkg.sv
package led_tx_pkg;

  typedef enum logic [1:0] {
    ORD_GRB = 2'd0,
    ORD_RGB = 2'd1,
    ORD_BGR = 2'd2
  } color_order_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } tx_state_e;

  // Nanoseconds to clock cycles, rounded to nearest.
  function automatic int unsigned ns_to_cyc(input longint unsigned clk_hz,
                                            input longint unsigned ns);
    return int'((ns * clk_hz + 64'd500_000_000) / 64'd1_000_000_000);
  endfunction

  // Microseconds to clock cycles.
  function automatic int unsigned us_to_cyc(input longint unsigned clk_hz,
                                            input longint unsigned us);
    return int'((us * clk_hz) / 64'd1_000_000);
  endfunction

  // Arrange the colour bytes in wire order; white always in the lowest byte.
  function automatic logic [31:0] wire_word(input color_order_e ord,
                                            input logic [7:0] r,
                                            input logic [7:0] g,
                                            input logic [7:0] b,
                                            input logic [7:0] w);
    case (ord)
      ORD_RGB: return {r, g, b, w};
      ORD_BGR: return {b, g, r, w};
      default: return {g, r, b, w};
    endcase
  endfunction

endpackage

// File: rtl/led_tx_bitcell.sv
module led_tx_bitcell #(
  parameter int unsigned PERIOD = 125,
  parameter int unsigned HI_ONE = 90,
  parameter int unsigned HI_ZERO = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bit_val,
  output logic line,
  output logic cell_end
);
  localparam int unsigned CW = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign cell_end = run && (cnt_q == CW'(PERIOD - 1));
  assign line     = run && (cnt_q < (bit_val ? CW'(HI_ONE) : CW'(HI_ZERO)));

  always_comb begin
    cnt_d = cnt_q;
    if (!run || cell_end) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: every cell restarts from zero after its last cycle
  a_r2_cell_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    cell_end |=> (cnt_q == '0));
  // R2: counter never passes the cell length
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(PERIOD));
endmodule

// File: rtl/led_tx_shifter.sv
module led_tx_shifter #(
  parameter int unsigned NBITS = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [NBITS-1:0] word,
  output logic             cur_bit,
  output logic             at_last
);
  localparam int unsigned IW = $clog2(NBITS);

  logic [NBITS-1:0] sh_q, sh_d;
  logic [IW-1:0]    idx_q, idx_d;

  assign cur_bit = sh_q[NBITS-1];
  assign at_last = (idx_q == IW'(NBITS - 1));

  always_comb begin
    sh_d  = sh_q;
    idx_d = idx_q;
    if (load) begin
      sh_d  = word;
      idx_d = '0;
    end else if (shift) begin
      sh_d  = {sh_q[NBITS-2:0], 1'b0};
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end

  // R5: bit index stays inside the pixel word
  a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IW'(NBITS - 1));
  // R5: a shift never happens on the final bit, a load must follow instead
  a_r5_no_overshift: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |-> !at_last);
endmodule

// File: rtl/led_serial_tx.sv
module led_serial_tx
  import led_tx_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned     GAP_US    = 6,
  parameter color_order_e    ORDER     = ORD_GRB,
  parameter bit              HAS_WHITE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_last,
  input  logic [7:0] in_red,
  input  logic [7:0] in_green,
  input  logic [7:0] in_blue,
  input  logic [7:0] in_white,
  output logic       dout,
  output logic       busy,
  output logic       underrun
);
  localparam int unsigned PERIOD  = ns_to_cyc(CLK_HZ, 1250);
  localparam int unsigned HI_ONE  = ns_to_cyc(CLK_HZ, 900);
  localparam int unsigned HI_ZERO = ns_to_cyc(CLK_HZ, 350);
  localparam int unsigned GAP_CYC = us_to_cyc(CLK_HZ, GAP_US);
  localparam int unsigned NBITS   = HAS_WHITE ? 32 : 24;
  localparam int unsigned GW      = $clog2(GAP_CYC + 1);

  if (HI_ZERO < 1 || HI_ONE <= HI_ZERO || PERIOD <= HI_ONE || GAP_CYC < 1)
  begin : g_bad_timing
    $error("led_serial_tx: clock too slow for the bit timing");
  end

  tx_state_e        state_q, state_d;
  logic             init_q;
  logic             cur_last_q, cur_last_d;
  logic             nxt_vld_q, nxt_vld_d;
  logic             nxt_last_q, nxt_last_d;
  logic [NBITS-1:0] nxt_q, nxt_d;
  logic             und_q, und_d;
  logic [GW-1:0]    gap_q, gap_d;

  logic             accept, pix_end, have_next, load, shift;
  logic             cur_bit, at_last, cell_end, line;
  logic [31:0]      full_word;
  logic [NBITS-1:0] in_word, load_word;
  logic             load_last;

  assign full_word = wire_word(ORDER, in_red, in_green, in_blue, in_white);
  assign in_word   = full_word[31 -: NBITS];

  assign in_ready  = init_q && ((state_q == ST_IDLE) ||
                     (state_q == ST_SEND && at_last && !cur_last_q && !nxt_vld_q));
  assign accept    = in_valid && in_ready;
  assign pix_end   = cell_end && at_last;
  assign have_next = nxt_vld_q || (accept && state_q == ST_SEND);
  assign load_word = nxt_vld_q ? nxt_q : in_word;
  assign load_last = nxt_vld_q ? nxt_last_q : in_last;

  always_comb begin
    state_d    = state_q;
    cur_last_d = cur_last_q;
    nxt_vld_d  = nxt_vld_q;
    nxt_last_d = nxt_last_q;
    nxt_d      = nxt_q;
    und_d      = und_q;
    gap_d      = gap_q;
    load       = 1'b0;
    shift      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d    = ST_SEND;
          load       = 1'b1;
          cur_last_d = in_last;
          und_d      = 1'b0;
        end
      end
      ST_SEND: begin
        if (pix_end) begin
          if (have_next) begin
            load       = 1'b1;
            cur_last_d = load_last;
            nxt_vld_d  = 1'b0;
          end else begin
            state_d = ST_GAP;
            gap_d   = '0;
            if (!cur_last_q) und_d = 1'b1;
          end
        end else begin
          if (cell_end) shift = 1'b1;
          if (accept) begin
            nxt_vld_d  = 1'b1;
            nxt_d      = in_word;
            nxt_last_d = in_last;
          end
        end
      end
      default: begin
        if (gap_q == GW'(GAP_CYC - 1)) state_d = ST_IDLE;
        else                           gap_d   = gap_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      init_q     <= 1'b0;
      cur_last_q <= 1'b0;
      nxt_vld_q  <= 1'b0;
      nxt_last_q <= 1'b0;
      nxt_q      <= '0;
      und_q      <= 1'b0;
      gap_q      <= '0;
    end else begin
      state_q    <= state_d;
      init_q     <= 1'b1;
      cur_last_q <= cur_last_d;
      nxt_vld_q  <= nxt_vld_d;
      nxt_last_q <= nxt_last_d;
      nxt_q      <= nxt_d;
      und_q      <= und_d;
      gap_q      <= gap_d;
    end
  end

  led_tx_shifter #(.NBITS(NBITS)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .shift  (shift),
    .word   (load_word),
    .cur_bit(cur_bit),
    .at_last(at_last)
  );

  led_tx_bitcell #(.PERIOD(PERIOD), .HI_ONE(HI_ONE), .HI_ZERO(HI_ZERO)) u_cell (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state_q == ST_SEND),
    .bit_val (cur_bit),
    .line    (line),
    .cell_end(cell_end)
  );

  assign dout     = line;
  assign busy     = (state_q != ST_IDLE);
  assign underrun = und_q;

  // R1: nothing is taken before the post-reset cycle has passed
  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !init_q |-> !in_ready);
  // R8: a pixel handover starts the next cell high at once
  a_r8_handover: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND && pix_end && have_next) |=> (state_q == ST_SEND && dout));
  // R9: the latch gap is quiet and closed to input
  a_r9_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP) |-> (!dout && !in_ready && busy));
  // R10: underrun is raised only at the end of a starved pixel
  a_r10_underrun_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> ($past(state_q) == ST_SEND && state_q == ST_GAP));
  // R11: busy only drops when the gap finishes
  a_r11_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(state_q) == ST_GAP));
endmodule

// File: tb/sim_led_serial_tx.sv
module sim_led_rx (
  input  logic clk,
  input  logic line,
  output int   n,
  output logic bitv [512],
  output int   hil [512],
  output int   per [512]
);
  logic prev;
  int   hi, lo;
  bit   act;
  initial begin
    n = 0; prev = 1'b0; hi = 0; lo = 0; act = 1'b0;
  end
  always @(negedge clk) begin
    if (line) begin
      if (!prev) begin
        if (act && n < 512) begin
          bitv[n] = (hi > 62); hil[n] = hi; per[n] = hi + lo; n++;
        end
        hi = 1; lo = 0; act = 1'b1;
      end else hi++;
    end else if (act) begin
      lo++;
      if (lo >= 200 && n < 512) begin
        bitv[n] = (hi > 62); hil[n] = hi; per[n] = -1; n++; act = 1'b0;
      end
    end
    prev = line;
  end
endmodule

module sim_led_serial_tx;
  import led_tx_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [7:0] red, green, blue, white;
  logic       last;
  logic       vld [3];
  logic       rdy [3];
  logic       dout [3];
  logic       busy [3];
  logic       und [3];

  int   dn [3];
  logic dbit [3][512];
  int   dhi [3][512];
  int   dper [3][512];

  logic ebit [3][512];
  int   en [3];
  int   done_n [3];
  int   run [3];
  int   last_run [3];
  int   lowrun [3];
  int   gapviol;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  led_serial_tx u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld[0]), .in_ready(rdy[0]), .in_last(last),
    .in_red(red), .in_green(green), .in_blue(blue), .in_white(white),
    .dout(dout[0]), .busy(busy[0]), .underrun(und[0]));

  led_serial_tx #(.GAP_US(2), .ORDER(ORD_BGR), .HAS_WHITE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld[1]), .in_ready(rdy[1]), .in_last(last),
    .in_red(red), .in_green(green), .in_blue(blue), .in_white(white),
    .dout(dout[1]), .busy(busy[1]), .underrun(und[1]));

  led_serial_tx #(.ORDER(ORD_RGB)) u2 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld[2]), .in_ready(rdy[2]), .in_last(last),
    .in_red(red), .in_green(green), .in_blue(blue), .in_white(white),
    .dout(dout[2]), .busy(busy[2]), .underrun(und[2]));

  sim_led_rx d0 (.clk(clk), .line(dout[0]), .n(dn[0]), .bitv(dbit[0]), .hil(dhi[0]), .per(dper[0]));
  sim_led_rx d1 (.clk(clk), .line(dout[1]), .n(dn[1]), .bitv(dbit[1]), .hil(dhi[1]), .per(dper[1]));
  sim_led_rx d2 (.clk(clk), .line(dout[2]), .n(dn[2]), .bitv(dbit[2]), .hil(dhi[2]), .per(dper[2]));

  // busy span and gap monitors
  always @(negedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (busy[i] === 1'b1) run[i]++;
      else if (run[i] != 0) begin last_run[i] = run[i]; run[i] = 0; end
      if (busy[i] === 1'b1 && dout[i] === 1'b0) lowrun[i]++;
      else lowrun[i] = 0;
      if (lowrun[i] > 100 && rdy[i] !== 1'b0) gapviol++;
    end
  end

  // pixel table: {last, red, green, blue, white}
  localparam logic [32:0] VEC [4] = '{
    {1'b0, 8'hA5, 8'h3C, 8'h81, 8'h00},
    {1'b0, 8'h00, 8'hFF, 8'h0F, 8'h00},
    {1'b0, 8'h7E, 8'h01, 8'hC3, 8'h00},
    {1'b1, 8'h96, 8'h5A, 8'h24, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int i, input logic [7:0] pr, input logic [7:0] pg,
                      input logic [7:0] pb, input logic [7:0] pw, input logic pl);
    logic [31:0] wd;
    int nb;
    case (i)
      0: begin wd = {pg, pr, pb, 8'h00}; nb = 24; end
      1: begin wd = {pb, pg, pr, pw};    nb = 32; end
      default: begin wd = {pr, pg, pb, 8'h00}; nb = 24; end
    endcase
    for (int k = 0; k < nb; k++) begin
      ebit[i][en[i]] = wd[31-k];
      en[i]++;
    end
    red = pr; green = pg; blue = pb; white = pw; last = pl;
    vld[i] = 1'b1;
    while (rdy[i] !== 1'b1) @(negedge clk);
    @(negedge clk);
    vld[i] = 1'b0;
  endtask

  task automatic end_frame(input int i, input int exp_run);
    while (busy[i] === 1'b1) @(negedge clk);
    @(negedge clk);
    chk(dn[i] == en[i], "R6 R7 bit count", dn[i], en[i]);
    for (int k = done_n[i]; k < en[i] && k < 512; k++) begin
      chk(dbit[i][k] == ebit[i][k], "R5 R6 R7 bit value", int'(dbit[i][k]), int'(ebit[i][k]));
      if (ebit[i][k]) chk(dhi[i][k] == 90, "R3 one high time", dhi[i][k], 90);
      else            chk(dhi[i][k] == 35, "R4 zero high time", dhi[i][k], 35);
      if (k != en[i] - 1) chk(dper[i][k] == 125, "R2 R8 cell period", dper[i][k], 125);
    end
    chk(last_run[i] == exp_run, "R9 R11 busy span", last_run[i], exp_run);
    done_n[i] = en[i];
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      vld[i] = 1'b0; en[i] = 0; done_n[i] = 0; run[i] = 0; last_run[i] = 0; lowrun[i] = 0;
    end
    gapviol = 0;
    red = 0; green = 0; blue = 0; white = 0; last = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      chk(rdy[i] == 1'b0, "R1 ready in reset", int'(rdy[i]), 0);
      chk(dout[i] == 1'b0 && busy[i] == 1'b0, "R1 idle outputs", int'(dout[i]), 0);
    end
    rst_n = 1'b1;
    #1;
    chk(rdy[0] == 1'b0, "R1 ready first cycle", int'(rdy[0]), 0);
    @(negedge clk);
    chk(rdy[0] == 1'b1, "R1 ready after", int'(rdy[0]), 1);
    chk(und[0] == 1'b0, "R10 underrun idle", int'(und[0]), 0);

    // table-driven frame on the default instance (GRB, R6)
    foreach (VEC[v]) push(0, VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], VEC[v][32]);
    end_frame(0, 4 * 24 * 125 + 600);
    chk(und[0] == 1'b0, "R10 no underrun on full frame", int'(und[0]), 0);

    // R8: second pixel taken on the final cycle of the first pixel
    push(0, 8'h11, 8'h80, 8'h01, 8'h00, 1'b0);
    repeat (2999) @(negedge clk);
    push(0, 8'hF0, 8'h0F, 8'hAA, 8'h00, 1'b1);
    end_frame(0, 2 * 24 * 125 + 600);
    chk(und[0] == 1'b0, "R8 late handover no underrun", int'(und[0]), 0);

    // R10: starved frame
    push(0, 8'h55, 8'h33, 8'hCC, 8'h00, 1'b0);
    end_frame(0, 24 * 125 + 600);
    chk(und[0] == 1'b1, "R10 underrun raised", int'(und[0]), 1);
    repeat (20) @(negedge clk);
    chk(und[0] == 1'b1, "R10 underrun held", int'(und[0]), 1);
    push(0, 8'h01, 8'h02, 8'h04, 8'h00, 1'b1);
    chk(und[0] == 1'b0, "R10 underrun cleared on new frame", int'(und[0]), 0);
    end_frame(0, 24 * 125 + 600);

    // R7 and BGR order with white, 2 us gap
    push(1, 8'hC1, 8'h22, 8'h9E, 8'h5B, 1'b0);
    push(1, 8'h0D, 8'hF7, 8'h60, 8'hE8, 1'b1);
    end_frame(1, 2 * 32 * 125 + 200);

    // R6: RGB order
    push(2, 8'hB4, 8'h4B, 8'h18, 8'h00, 1'b1);
    end_frame(2, 24 * 125 + 600);

    chk(gapviol == 0, "R9 ready low during gap", gapviol, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule